// File: doc/BRIEF.md
# Configuration Access Port Decoder

This block sits on the I/O port path of a host bridge. It turns port reads and writes into configuration cycles. Each I/O request carries a 16-bit port address, 32-bit data and a byte length. The block keeps one 32-bit configuration address word, which software loads through the address port at 0x0CF8. When that word's enable bit is set, accesses to the four data ports 0x0CFC..0x0CFF become configuration cycles. The cycle targets the bus, device/function and dword named by the latched word.

Cycles aimed at bus 0, device/function 0 are served by a small register file inside the bridge. Every other target is sent over a downstream request interface and held there until a device acknowledges it or a timeout expires. Any access the block does not claim completes at once, with an unclaimed flag raised.

The requester keeps at most one request in flight. It waits for the response pulse before it issues the next request.

Top module: `cfgport_top`

## Requirements
- R1: After reset the configuration address word is zero. A 4-byte read of 0x0CF8 returns 0, and a data-port access is unclaimed.
- R2: A 4-byte write to 0x0CF8 loads the full 32-bit address word. A 4-byte read of 0x0CF8 returns the word unchanged.
- R3: A 1- or 2-byte access to 0x0CF8 leaves the address word untouched and completes unclaimed.
- R4: While bit 31 (enable) of the address word is clear, data-port accesses complete unclaimed. They issue no downstream request and change no internal register.
- R5: The target fields come from the address word: bus from bits 23:16, device/function from bits 15:8, and dword index from bits 7:2. Bus 0 with device/function 0 goes to the internal register file. Any other target goes downstream with those field values.
- R6: For port byte offset o (port minus 0x0CFC) and length L, the byte enables are ((1<<L)-1)<<o and write data is shifted left by 8*o. An access with o+L>4, or with L not in {1,2,4}, is unclaimed.
- R7: Read data from the selected dword is shifted right by 8*o, and bytes above L are returned as zero.
- R8: Internal register dword 0 is read-only and holds {DEVICE_ID, VENDOR_ID}. Dwords 1..HOST_DWORDS-1 are read-write per enabled byte and reset to zero. Dwords at or above HOST_DWORDS read zero and ignore writes.
- R9: A downstream request holds valid and all its fields stable until ds_ack. A read then returns ds_rdata, aligned as in R7.
- R10: If no ds_ack arrives within TIMEOUT cycles of valid, the request is withdrawn. A read then returns all ones aligned as in R7, and a write simply completes. An ack in the last allowed cycle still wins.
- R11: Any other port, and any unclaimed access, completes with io_unclaimed high, and its read data is 0xFFFFFFFF.
- R12: Local responses (address port, internal registers, unclaimed) arrive one cycle after the request. A downstream response arrives one cycle after the ack or the expiry. io_unclaimed is high only together with io_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req_valid | input | 1 | One-cycle I/O request strobe |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_len | input | 3 | Access length in bytes |
| io_wdata | input | 32 | Write data, low-justified |
| io_rsp_valid | output | 1 | One-cycle response strobe |
| io_rdata | output | 32 | Read data, low-justified |
| io_unclaimed | output | 1 | Access was not claimed |
| ds_req_valid | output | 1 | Downstream configuration request pending |
| ds_write | output | 1 | Downstream request is a write |
| ds_bus | output | 8 | Target bus number |
| ds_devfn | output | 8 | Target device/function |
| ds_reg | output | 6 | Target dword index |
| ds_be | output | 4 | Byte enables |
| ds_wdata | output | 32 | Lane-aligned write data |
| ds_ack | input | 1 | Downstream completion |
| ds_rdata | input | 32 | Downstream read dword |

## Verification
The bench sweeps every legal offset and length pair against every internal dword, including dword 0 and one index past the end. A lane or byte-enable slip would corrupt neighbouring bytes, and a missing range check would create phantom storage; both show up against the bench's byte model. Narrow accesses to the address port and accesses with the enable bit clear are followed by reads of the state they could have touched. A design that latched on any length, or that forwarded without the enable bit, would therefore return changed values or raise a stray downstream request.

Downstream reads run with no ack, and with an ack in exactly the last allowed cycle. An off-by-one timeout would either return all ones where ack data was due, or hang. Targets with bus 0 but non-zero device/function, and the reverse, make sure routing tests both fields.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam logic [15:0] ADDR_PORT  = 16'h0CF8;
    localparam logic [15:0] DATA_PORT  = 16'h0CFC;
    localparam int          ENABLE_BIT = 31;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ADDR = 2'd1,
        TGT_HOST = 2'd2,
        TGT_DOWN = 2'd3
    } tgt_e;

    typedef enum logic {
        DS_IDLE = 1'b0,
        DS_BUSY = 1'b1
    } ds_state_e;

    typedef struct packed {
        tgt_e        tgt;
        logic        write;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [5:0]  dw;
        logic [1:0]  ofs;
        logic [2:0]  len;
        logic [3:0]  be;
        logic [31:0] lane_data;
    } cfg_cyc_t;

    // Legal combinations of byte offset and length stay inside one dword.
    function automatic logic span_ok(input logic [1:0] ofs, input logic [2:0] len);
        case (len)
            3'd1:    return 1'b1;
            3'd2:    return ofs != 2'd3;
            3'd4:    return ofs == 2'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] lane_be(input logic [1:0] ofs, input logic [2:0] len);
        case (len)
            3'd1:    return 4'b0001 << ofs;
            3'd2:    return 4'b0011 << ofs;
            3'd4:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] lane_place(input logic [31:0] data, input logic [1:0] ofs);
        return data << {ofs, 3'b000};
    endfunction

    function automatic logic [31:0] lane_pick(input logic [31:0] dword, input logic [1:0] ofs,
                                              input logic [2:0] len);
        logic [31:0] s;
        s = dword >> {ofs, 3'b000};
        case (len)
            3'd1:    return {24'h0, s[7:0]};
            3'd2:    return {16'h0, s[15:0]};
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
(
    input  logic        io_write,
    input  logic [15:0] io_addr,
    input  logic [2:0]  io_len,
    input  logic [31:0] io_wdata,
    input  logic        cfg_en,
    input  logic [7:0]  cfg_bus,
    input  logic [7:0]  cfg_devfn,
    input  logic [5:0]  cfg_dw,
    output cfg_cyc_t    cyc
);

    logic addr_hit;
    logic data_hit;
    logic local_tgt;

    always_comb begin
        addr_hit  = (io_addr == ADDR_PORT) && (io_len == 3'd4);
        data_hit  = (io_addr[15:2] == DATA_PORT[15:2]) && cfg_en && span_ok(io_addr[1:0], io_len);
        local_tgt = (cfg_bus == 8'h00) && (cfg_devfn == 8'h00);

        cyc.write     = io_write;
        cyc.bus       = cfg_bus;
        cyc.devfn     = cfg_devfn;
        cyc.dw        = cfg_dw;
        cyc.ofs       = io_addr[1:0];
        cyc.len       = io_len;
        cyc.be        = lane_be(io_addr[1:0], io_len);
        cyc.lane_data = lane_place(io_wdata, io_addr[1:0]);

        if (addr_hit)       cyc.tgt = TGT_ADDR;
        else if (data_hit)  cyc.tgt = local_tgt ? TGT_HOST : TGT_DOWN;
        else                cyc.tgt = TGT_NONE;
    end

endmodule

// File: rtl/cfgport_hostregs.sv
module cfgport_hostregs #(
    parameter int          HOST_DWORDS = 8,
    parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID   = 16'h7A31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [5:0]  dw,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    localparam int IW = (HOST_DWORDS > 2) ? $clog2(HOST_DWORDS) : 1;

    logic [31:0] rd_arr [HOST_DWORDS];

    assign rd_arr[0] = {DEVICE_ID, VENDOR_ID};

    for (genvar i = 1; i < HOST_DWORDS; i++) begin : g_dword
        logic [31:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (int'(dw) == i)) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) q[b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
        assign rd_arr[i] = q;
    end

    always_comb begin
        if (int'(dw) < HOST_DWORDS) rdata = rd_arr[dw[IW-1:0]];
        else                        rdata = '0;
    end

endmodule

// File: rtl/cfgport_dsctl.sv
module cfgport_dsctl
    import cfgport_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        write,
    input  logic [7:0]  bus,
    input  logic [7:0]  devfn,
    input  logic [5:0]  dw,
    input  logic [3:0]  be,
    input  logic [1:0]  ofs,
    input  logic [2:0]  len,
    input  logic [31:0] lane_data,
    output logic        ds_req_valid,
    output logic        ds_write,
    output logic [7:0]  ds_bus,
    output logic [7:0]  ds_devfn,
    output logic [5:0]  ds_reg,
    output logic [3:0]  ds_be,
    output logic [31:0] ds_wdata,
    input  logic        ds_ack,
    input  logic [31:0] ds_rdata,
    output logic        done,
    output logic [31:0] done_data
);

    localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

    ds_state_e   state_q;
    logic [TW-1:0] tmo_q;
    logic        wr_q;
    logic [7:0]  bus_q;
    logic [7:0]  devfn_q;
    logic [5:0]  dw_q;
    logic [3:0]  be_q;
    logic [1:0]  ofs_q;
    logic [2:0]  len_q;
    logic [31:0] data_q;
    logic        expire;

    assign expire    = (tmo_q == TW'(TIMEOUT - 1));
    assign done      = (state_q == DS_BUSY) && (ds_ack || expire);
    assign done_data = wr_q ? 32'h0 : lane_pick(ds_ack ? ds_rdata : 32'hFFFF_FFFF, ofs_q, len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_IDLE;
            tmo_q   <= '0;
            wr_q    <= 1'b0;
            bus_q   <= '0;
            devfn_q <= '0;
            dw_q    <= '0;
            be_q    <= '0;
            ofs_q   <= '0;
            len_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                DS_IDLE: begin
                    if (start) begin
                        state_q <= DS_BUSY;
                        tmo_q   <= '0;
                        wr_q    <= write;
                        bus_q   <= bus;
                        devfn_q <= devfn;
                        dw_q    <= dw;
                        be_q    <= be;
                        ofs_q   <= ofs;
                        len_q   <= len;
                        data_q  <= lane_data;
                    end
                end
                default: begin
                    if (done) state_q <= DS_IDLE;
                    else      tmo_q   <= tmo_q + 1'b1;
                end
            endcase
        end
    end

    assign ds_req_valid = (state_q == DS_BUSY);
    assign ds_write     = wr_q;
    assign ds_bus       = bus_q;
    assign ds_devfn     = devfn_q;
    assign ds_reg       = dw_q;
    assign ds_be        = be_q;
    assign ds_wdata     = data_q;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int          HOST_DWORDS = 8,
    parameter int          TIMEOUT     = 16,
    parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID   = 16'h7A31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_req_valid,
    input  logic        io_req_write,
    input  logic [15:0] io_addr,
    input  logic [2:0]  io_len,
    input  logic [31:0] io_wdata,
    output logic        io_rsp_valid,
    output logic [31:0] io_rdata,
    output logic        io_unclaimed,
    output logic        ds_req_valid,
    output logic        ds_write,
    output logic [7:0]  ds_bus,
    output logic [7:0]  ds_devfn,
    output logic [5:0]  ds_reg,
    output logic [3:0]  ds_be,
    output logic [31:0] ds_wdata,
    input  logic        ds_ack,
    input  logic [31:0] ds_rdata
);

    logic [31:0] cfg_addr_q;
    cfg_cyc_t    cyc;
    logic [31:0] host_rdata;
    logic        host_wr;
    logic        ds_start;
    logic        ds_done;
    logic [31:0] ds_done_data;
    logic        rsp_valid_q;
    logic [31:0] rsp_data_q;
    logic        uncl_q;

    cfgport_decode u_decode (
        .io_write  (io_req_write),
        .io_addr   (io_addr),
        .io_len    (io_len),
        .io_wdata  (io_wdata),
        .cfg_en    (cfg_addr_q[ENABLE_BIT]),
        .cfg_bus   (cfg_addr_q[23:16]),
        .cfg_devfn (cfg_addr_q[15:8]),
        .cfg_dw    (cfg_addr_q[7:2]),
        .cyc       (cyc)
    );

    assign host_wr  = io_req_valid && (cyc.tgt == TGT_HOST) && cyc.write;
    assign ds_start = io_req_valid && (cyc.tgt == TGT_DOWN);

    cfgport_hostregs #(
        .HOST_DWORDS (HOST_DWORDS),
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID)
    ) u_hostregs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (host_wr),
        .dw    (cyc.dw),
        .be    (cyc.be),
        .wdata (cyc.lane_data),
        .rdata (host_rdata)
    );

    cfgport_dsctl #(
        .TIMEOUT (TIMEOUT)
    ) u_dsctl (
        .clk          (clk),
        .rst          (rst),
        .start        (ds_start),
        .write        (cyc.write),
        .bus          (cyc.bus),
        .devfn        (cyc.devfn),
        .dw           (cyc.dw),
        .be           (cyc.be),
        .ofs          (cyc.ofs),
        .len          (cyc.len),
        .lane_data    (cyc.lane_data),
        .ds_req_valid (ds_req_valid),
        .ds_write     (ds_write),
        .ds_bus       (ds_bus),
        .ds_devfn     (ds_devfn),
        .ds_reg       (ds_reg),
        .ds_be        (ds_be),
        .ds_wdata     (ds_wdata),
        .ds_ack       (ds_ack),
        .ds_rdata     (ds_rdata),
        .done         (ds_done),
        .done_data    (ds_done_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_addr_q  <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            uncl_q      <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            uncl_q      <= 1'b0;
            if (ds_done) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= ds_done_data;
            end
            if (io_req_valid) begin
                case (cyc.tgt)
                    TGT_ADDR: begin
                        if (cyc.write) cfg_addr_q <= io_wdata;
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= cyc.write ? 32'h0 : cfg_addr_q;
                    end
                    TGT_HOST: begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= cyc.write ? 32'h0 : lane_pick(host_rdata, cyc.ofs, cyc.len);
                    end
                    TGT_DOWN: begin
                        // completion comes from the downstream controller
                    end
                    default: begin
                        rsp_valid_q <= 1'b1;
                        uncl_q      <= 1'b1;
                        rsp_data_q  <= 32'hFFFF_FFFF;
                    end
                endcase
            end
        end
    end

    assign io_rsp_valid = rsp_valid_q;
    assign io_rdata     = rsp_data_q;
    assign io_unclaimed = uncl_q;

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
    parameter int TIMEOUT = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        io_req_valid,
    input logic        io_req_write,
    input logic [15:0] io_addr,
    input logic [2:0]  io_len,
    input logic [31:0] io_wdata,
    input logic        io_rsp_valid,
    input logic [31:0] io_rdata,
    input logic        io_unclaimed,
    input logic [31:0] cfg_addr,
    input logic        ds_req_valid,
    input logic        ds_ack,
    input logic        ds_write,
    input logic [7:0]  ds_bus,
    input logic [7:0]  ds_devfn,
    input logic [5:0]  ds_reg,
    input logic [3:0]  ds_be
);

    localparam int CW = $clog2(TIMEOUT + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)               busy_cnt <= '0;
        else if (ds_req_valid) busy_cnt <= busy_cnt + 1'b1;
        else                   busy_cnt <= '0;
    end

    AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (rst)
        io_req_valid && io_req_write && io_addr == 16'h0CF8 && io_len == 3'd4
        |=> cfg_addr == $past(io_wdata)); // R2

    AST_ADDR_NARROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        io_req_valid && io_addr == 16'h0CF8 && io_len != 3'd4
        |=> $stable(cfg_addr)); // R3

    AST_DISABLED_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        io_req_valid && !cfg_addr[31] && !ds_req_valid
        |=> !ds_req_valid); // R4

    AST_DS_NOT_LOCAL: assert property (@(posedge clk) disable iff (rst)
        ds_req_valid |-> (ds_bus != 8'h00 || ds_devfn != 8'h00)); // R5

    AST_DS_BE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        ds_req_valid |-> ds_be != 4'h0); // R6

    AST_DS_HOLD: assert property (@(posedge clk) disable iff (rst)
        ds_req_valid && !ds_ack
        |=> !ds_req_valid || $stable({ds_write, ds_bus, ds_devfn, ds_reg, ds_be})); // R9

    AST_DS_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= CW'(TIMEOUT)); // R10

    AST_UNCL_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        io_rsp_valid && io_unclaimed |-> io_rdata == 32'hFFFF_FFFF); // R11

    AST_UNCL_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        io_unclaimed |-> io_rsp_valid); // R12

    AST_LOCAL_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        io_req_valid && !ds_req_valid |=> io_rsp_valid || ds_req_valid); // R12

endmodule

bind cfgport_top cfgport_checker #(.TIMEOUT(TIMEOUT)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .io_req_valid (io_req_valid),
    .io_req_write (io_req_write),
    .io_addr      (io_addr),
    .io_len       (io_len),
    .io_wdata     (io_wdata),
    .io_rsp_valid (io_rsp_valid),
    .io_rdata     (io_rdata),
    .io_unclaimed (io_unclaimed),
    .cfg_addr     (cfg_addr_q),
    .ds_req_valid (ds_req_valid),
    .ds_ack       (ds_ack),
    .ds_write     (ds_write),
    .ds_bus       (ds_bus),
    .ds_devfn     (ds_devfn),
    .ds_reg       (ds_reg),
    .ds_be        (ds_be)
);

// File: tb/cfgport_top_tb_top.sv
`timescale 1ns/1ps
module cfgport_top_tb_top;

    localparam int          HD  = 8;
    localparam int          TMO = 8;
    localparam logic [15:0] VEN = 16'h1D0F;
    localparam logic [15:0] DEV = 16'h7A31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_req_valid = 1'b0;
    logic        io_req_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [2:0]  io_len = '0;
    logic [31:0] io_wdata = '0;
    logic        io_rsp_valid;
    logic [31:0] io_rdata;
    logic        io_unclaimed;
    logic        ds_req_valid;
    logic        ds_write;
    logic [7:0]  ds_bus;
    logic [7:0]  ds_devfn;
    logic [5:0]  ds_reg;
    logic [3:0]  ds_be;
    logic [31:0] ds_wdata;
    logic        ds_ack = 1'b0;
    logic [31:0] ds_rdata = '0;

    always #5 clk = ~clk;

    cfgport_top #(
        .HOST_DWORDS (HD),
        .TIMEOUT     (TMO),
        .VENDOR_ID   (VEN),
        .DEVICE_ID   (DEV)
    ) dut_i (
        .clk (clk), .rst (rst),
        .io_req_valid (io_req_valid), .io_req_write (io_req_write),
        .io_addr (io_addr), .io_len (io_len), .io_wdata (io_wdata),
        .io_rsp_valid (io_rsp_valid), .io_rdata (io_rdata), .io_unclaimed (io_unclaimed),
        .ds_req_valid (ds_req_valid), .ds_write (ds_write), .ds_bus (ds_bus),
        .ds_devfn (ds_devfn), .ds_reg (ds_reg), .ds_be (ds_be), .ds_wdata (ds_wdata),
        .ds_ack (ds_ack), .ds_rdata (ds_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // downstream responder
    int          ack_delay = 0;
    int          ds_cnt = 0;
    int          ds_starts = 0;
    logic        cap_write;
    logic [7:0]  cap_bus;
    logic [7:0]  cap_devfn;
    logic [5:0]  cap_reg;
    logic [3:0]  cap_be;
    logic [31:0] cap_wdata;

    function automatic logic [31:0] ds_value(input logic [7:0] b, input logic [7:0] f,
                                             input logic [5:0] r);
        return {b, f, 2'b01, r, 8'h3C};
    endfunction

    always @(negedge clk) begin
        if (ds_req_valid) begin
            if (ds_cnt == 0) ds_starts <= ds_starts + 1;
            cap_write <= ds_write; cap_bus <= ds_bus; cap_devfn <= ds_devfn;
            cap_reg <= ds_reg; cap_be <= ds_be; cap_wdata <= ds_wdata;
            if (ds_cnt == ack_delay) begin
                ds_ack   <= 1'b1;
                ds_rdata <= ds_value(ds_bus, ds_devfn, ds_reg);
            end else begin
                ds_ack <= 1'b0;
            end
            ds_cnt <= ds_cnt + 1;
        end else begin
            ds_cnt <= 0;
            ds_ack <= 1'b0;
        end
    end

    logic [31:0] r_data;
    logic        r_uncl;
    int          lat;
    logic [31:0] hmodel [HD];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic io(input logic w, input logic [15:0] a, input logic [2:0] l,
                      input logic [31:0] d);
        io_req_valid = 1'b1; io_req_write = w; io_addr = a; io_len = l; io_wdata = d;
        @(negedge clk);
        io_req_valid = 1'b0;
        lat = 1;
        while (!io_rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        r_data = io_rdata;
        r_uncl = io_unclaimed;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pick(input logic [31:0] v, input int o, input int l);
        logic [31:0] s;
        s = v >> (8 * o);
        if (l == 1) return s & 32'h0000_00FF;
        if (l == 2) return s & 32'h0000_FFFF;
        return s;
    endfunction

    function automatic logic [31:0] host_exp(input int dw);
        if (dw == 0)  return {DEV, VEN};
        if (dw < HD)  return hmodel[dw];
        return 32'h0;
    endfunction

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int lens [3] = '{1, 2, 4};
        for (int i = 0; i < HD; i++) hmodel[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        io(1'b0, 16'h0CF8, 3'd4, 32'h0);
        check("R1 addr word after reset", r_data, 32'h0);
        check("R1 addr port claimed", {31'h0, r_uncl}, 32'h0);
        io(1'b0, 16'h0CFC, 3'd4, 32'h0);
        check("R1 data port unclaimed after reset", {31'h0, r_uncl}, 32'h1);
        check("R1 data port reads ones", r_data, 32'hFFFF_FFFF);

        // R2 latch and readback
        io(1'b1, 16'h0CF8, 3'd4, 32'h1234_5678);
        check("R12 address write latency", lat, 1);
        io(1'b0, 16'h0CF8, 3'd4, 32'h0);
        check("R2 readback", r_data, 32'h1234_5678);
        io(1'b1, 16'h0CF8, 3'd4, 32'h8000_0004);
        io(1'b0, 16'h0CF8, 3'd4, 32'h0);
        check("R2 readback enabled word", r_data, 32'h8000_0004);

        // R3 narrow accesses to the address port
        io(1'b1, 16'h0CF8, 3'd1, 32'h0000_00AA);
        check("R3 byte write unclaimed", {31'h0, r_uncl}, 32'h1);
        io(1'b1, 16'h0CF8, 3'd2, 32'h0000_BBBB);
        check("R3 word write unclaimed", {31'h0, r_uncl}, 32'h1);
        io(1'b0, 16'h0CF8, 3'd2, 32'h0);
        check("R3 word read ones", r_data, 32'hFFFF_FFFF);
        io(1'b0, 16'h0CF8, 3'd4, 32'h0);
        check("R3 address word untouched", r_data, 32'h8000_0004);

        // R4 enable clear: no effect, no forwarding
        io(1'b1, 16'h0CF8, 3'd4, 32'h0000_0004);
        io(1'b1, 16'h0CFC, 3'd4, 32'hDEAD_BEEF);
        check("R4 disabled write unclaimed", {31'h0, r_uncl}, 32'h1);
        io(1'b1, 16'h0CF8, 3'd4, 32'h0003_1004);
        io(1'b0, 16'h0CFC, 3'd4, 32'h0);
        check("R4 disabled downstream read unclaimed", {31'h0, r_uncl}, 32'h1);
        check("R4 no downstream request", ds_starts, 0);
        io(1'b1, 16'h0CF8, 3'd4, 32'h8000_0004);
        io(1'b0, 16'h0CFC, 3'd4, 32'h0);
        check("R4 host dword untouched", r_data, 32'h0);

        // R6 R7 R8 host sweep
        for (int dw = 0; dw <= HD; dw++) begin
            io(1'b1, 16'h0CF8, 3'd4, 32'h8000_0000 | (dw << 2));
            for (int o = 0; o < 4; o++) begin
                for (int li = 0; li < 3; li++) begin
                    int l = lens[li];
                    if (o + l <= 4) begin
                        logic [31:0] p;
                        logic [31:0] lane;
                        logic [3:0]  be;
                        p    = 32'h5A00_0000 ^ (dw * 32'h0103_0507) ^ (o << 12) ^ (l << 4) ^ 32'h0000_9C00;
                        lane = p << (8 * o);
                        be   = ((l == 1) ? 4'h1 : (l == 2) ? 4'h3 : 4'hF) << o;
                        io(1'b1, 16'h0CFC + 16'(o), 3'(l), p);
                        check("R12 host write latency", lat, 1);
                        check("R6 host write claimed", {31'h0, r_uncl}, 32'h0);
                        if (dw >= 1 && dw < HD) begin
                            for (int b = 0; b < 4; b++)
                                if (be[b]) hmodel[dw][b*8 +: 8] = lane[b*8 +: 8];
                        end
                        io(1'b0, 16'h0CFC, 3'd4, 32'h0);
                        check($sformatf("R8 R6 dword %0d after o%0d l%0d", dw, o, l), r_data, host_exp(dw));
                        io(1'b0, 16'h0CFC + 16'(o), 3'(l), 32'h0);
                        check($sformatf("R7 narrow read dword %0d o%0d l%0d", dw, o, l), r_data,
                              pick(host_exp(dw), o, l));
                    end
                end
            end
        end

        // R6 R11 illegal spans and lengths
        io(1'b0, 16'h0CFF, 3'd2, 32'h0);
        check("R6 word crossing dword unclaimed", {31'h0, r_uncl}, 32'h1);
        io(1'b0, 16'h0CFD, 3'd4, 32'h0);
        check("R6 misaligned dword unclaimed", r_data, 32'hFFFF_FFFF);
        io(1'b0, 16'h0CFC, 3'd3, 32'h0);
        check("R6 length three unclaimed", {31'h0, r_uncl}, 32'h1);
        io(1'b0, 16'h0080, 3'd1, 32'h0);
        check("R11 other port unclaimed", {31'h0, r_uncl}, 32'h1);
        check("R11 other port reads ones", r_data, 32'hFFFF_FFFF);
        check("R12 unclaimed latency", lat, 1);
        io(1'b0, 16'h0CF9, 3'd1, 32'h0);
        check("R11 port 0x0CF9 unclaimed", {31'h0, r_uncl}, 32'h1);

        // R5 R9 R6 downstream, bus 3 devfn 0x10 dword 9
        io(1'b1, 16'h0CF8, 3'd4, 32'h8003_1024);
        for (int o = 0; o < 4; o++) begin
            for (int li = 0; li < 3; li++) begin
                int l = lens[li];
                if (o + l <= 4) begin
                    logic [31:0] p;
                    p = 32'hC3A5_0000 | (o << 8) | l;
                    ack_delay = 1;
                    io(1'b1, 16'h0CFC + 16'(o), 3'(l), p);
                    check("R9 downstream write latency", lat, 3);
                    check("R5 bus", cap_bus, 32'h03);
                    check("R5 devfn", cap_devfn, 32'h10);
                    check("R5 reg", cap_reg, 32'h09);
                    check("R6 byte enables", cap_be, ((l == 1) ? 4'h1 : (l == 2) ? 4'h3 : 4'hF) << o);
                    check("R6 lane data", cap_wdata, p << (8 * o));
                    check("R9 write flag", cap_write, 1);
                    ack_delay = 0;
                    io(1'b0, 16'h0CFC + 16'(o), 3'(l), 32'h0);
                    check("R12 downstream read latency", lat, 2);
                    check("R9 read data", r_data, pick(ds_value(8'h03, 8'h10, 6'h09), o, l));
                end
            end
        end

        // R5 bus 0 with devfn nonzero, and bus nonzero with devfn 0
        io(1'b1, 16'h0CF8, 3'd4, 32'h8000_0814);
        ack_delay = 2;
        io(1'b0, 16'h0CFC, 3'd4, 32'h0);
        check("R5 bus0 devfn8 forwarded", r_data, ds_value(8'h00, 8'h08, 6'h05));
        check("R9 ack delay two latency", lat, 4);
        io(1'b1, 16'h0CF8, 3'd4, 32'h8007_0008);
        io(1'b0, 16'h0CFE, 3'd2, 32'h0);
        check("R5 bus7 devfn0 forwarded", r_data, pick(ds_value(8'h07, 8'h00, 6'h02), 2, 2));

        // R10 timeout
        ack_delay = -1;
        io(1'b0, 16'h0CFE, 3'd2, 32'h0);
        check("R10 timeout read ones", r_data, 32'h0000_FFFF);
        check("R10 timeout latency", lat, TMO + 1);
        check("R10 timeout claimed", {31'h0, r_uncl}, 32'h0);
        check("R10 request withdrawn", ds_req_valid, 0);
        io(1'b1, 16'h0CFC, 3'd4, 32'h1111_2222);
        check("R10 timeout write completes", r_data, 32'h0);
        check("R10 write timeout latency", lat, TMO + 1);
        ack_delay = TMO - 1;
        io(1'b0, 16'h0CFC, 3'd4, 32'h0);
        check("R10 last-cycle ack wins", r_data, ds_value(8'h07, 8'h00, 6'h02));
        check("R10 last-cycle ack latency", lat, TMO + 1);

        summary();
    end

endmodule